// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Generator

This block makes one pulse-width-modulated output from a fast reference clock (nominally 24 MHz). A 4-bit code picks a divisor from a fixed table of irregular values. The divided clock produces ticks, and each tick advances a 16-bit waveform counter. The counter runs from zero up to a programmed end count and then wraps. The output is in its active state for the first DUTY ticks of each period. A polarity bit decides whether the active state is a high or a low level.

Software drives the block through two 32-bit words on a simple word bus. The control word sits at offset 0 and the timing word at offset 4. Both words read back exactly what was written. There is no flow control: every write is accepted in its cycle, and read data follows one cycle after the read strobe.

A gate bit controls the prescaled clock. The prescaler code is sampled only while the gate is low. To change the rate, software clears the gate, writes the new code, then sets the gate again. New timing values wait in a shadow copy and are loaded at a period boundary, so a running period is never cut short.

Top module: `pwm_timer`

## Requirements
- R1: The control word (offset 0) and the timing word (offset 4) hold all 32 written bits and read them back unchanged. Reads of any other offset return zero, and writes to other offsets are ignored.
- R2: Control bits [3:0] select the tick divisor: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1 (one tick per clock).
- R3: Codes 5, 6, 7, 13 and 14 are reserved. While one of them is the sampled code, the counter stays stopped and the output holds its inactive level. Selecting a valid code afterwards restarts normal operation.
- R4: Timing word bits [31:16] hold END and bits [15:0] hold DUTY. A period lasts END+1 ticks, and the output is active while the count is below DUTY. DUTY=0 gives an output that is never active. DUTY greater than END gives an output that is always active.
- R5: Control bit 5 is the polarity bit. A value of 1 makes the active state high, and 0 makes the active state low.
- R6: When control bit 4 (enable) is 0, or control bit 6 (gate) is 0, the counter is held at zero and the output drives the inactive level.
- R7: The divisor code is sampled only in cycles where the gate is 0. Writing a new code while the gate is 1 does not change the tick rate until the gate has been cleared and set again.
- R8: A timing-word write made while the counter runs takes effect at the next period boundary. This includes a write that lands in the same cycle as the boundary: the period that starts at that boundary still uses the old values. While the counter is stopped, a new timing word takes effect at once.
- R9: Read data appears on the read-data port in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte offset of the word (0 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pwm_o | output | 1 | PWM output |

## Verification
The case that needs care is a timing-word write landing in the same clock edge at which the counter wraps and reloads its shadow copy. The bench synchronises to a rising output edge and counts clocks so that the write strobe lands exactly on the wrap edge, with a one-tick-per-clock divisor and a ten-tick period. It then times the next high and low phases, which must still match the old values, and the phases after them, which must match the new values. A second case of the same kind writes a new divisor code while the gate is set. The bench checks that the measured phase lengths stay the same until the gate has been cleared and set again.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DIV_W        = 17;
  localparam int CODE_W       = 4;
  localparam int CTRL_EN_BIT  = 4;
  localparam int CTRL_POL_BIT = 5;
  localparam int CTRL_GATE_BIT = 6;
  localparam int CTRL_USED_W  = 7;

  // Divisor table; zero marks a reserved code.
  function automatic logic [DIV_W-1:0] psc_div(input logic [CODE_W-1:0] code);
    case (code)
      4'h0:    return DIV_W'(120);
      4'h1:    return DIV_W'(180);
      4'h2:    return DIV_W'(240);
      4'h3:    return DIV_W'(360);
      4'h4:    return DIV_W'(480);
      4'h8:    return DIV_W'(12000);
      4'h9:    return DIV_W'(24000);
      4'hA:    return DIV_W'(36000);
      4'hB:    return DIV_W'(48000);
      4'hC:    return DIV_W'(72000);
      4'hF:    return DIV_W'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic psc_ok(input logic [CODE_W-1:0] code);
    return psc_div(code) != '0;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int CTRL_OUT_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  input  logic                  we,
  input  logic                  re,
  output logic [DW-1:0]         rdata,
  output logic [CTRL_OUT_W-1:0] ctrl_o,
  output logic [DW-1:0]         timing_o
);
  localparam logic [AW-1:0] OFS_CTRL   = AW'(0);
  localparam logic [AW-1:0] OFS_TIMING = AW'(4);

  logic [DW-1:0] ctrl_q, timing_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      timing_q <= '0;
      rdata    <= '0;
    end else begin
      if (we && addr == OFS_CTRL)   ctrl_q   <= wdata;
      if (we && addr == OFS_TIMING) timing_q <= wdata;
      if (re) begin
        case (addr)
          OFS_CTRL:   rdata <= ctrl_q;
          OFS_TIMING: rdata <= timing_q;
          default:    rdata <= '0;
        endcase
      end
    end
  end

  assign ctrl_o   = ctrl_q[CTRL_OUT_W-1:0];
  assign timing_o = timing_q;

  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_CTRL) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int PW = DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              gate_i,
  input  logic              en_i,
  output logic              run_o,
  output logic              tick_o
);
  logic [CODE_W-1:0] act_code;
  logic [PW-1:0]     pcnt;
  logic [PW-1:0]     last;

  // Code is sampled only while the gate is off.
  always_ff @(posedge clk) begin
    if (!rst_n)       act_code <= '0;
    else if (!gate_i) act_code <= code_i;
  end

  assign last   = PW'(psc_div(act_code)) - PW'(1);
  assign run_o  = en_i && gate_i && psc_ok(act_code);
  assign tick_o = run_o && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_o) pcnt <= '0;
    else if (pcnt == last) pcnt <= '0;
    else                   pcnt <= pcnt + PW'(1);
  end

  assert_code_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i |=> (!gate_i || act_code == $past(act_code)));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          pol_i,
  input  logic [CW-1:0] end_i,
  input  logic [CW-1:0] duty_i,
  output logic          pwm_o
);
  logic [CW-1:0] cnt, act_end, act_duty;
  logic          active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_end  <= '0;
      act_duty <= '0;
    end else if (!run_i) begin
      cnt      <= '0;
      act_end  <= end_i;
      act_duty <= duty_i;
    end else if (tick_i) begin
      if (cnt == act_end) begin
        cnt      <= '0;
        act_end  <= end_i;
        act_duty <= duty_i;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign active = run_i && (cnt < act_duty);
  assign pwm_o  = active ? pol_i : !pol_i;

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_end);
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));
  assert_shadow_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !(tick_i && cnt == act_end)) |=> ($stable(act_end) && $stable(act_duty)));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_o
);
  logic [CTRL_USED_W-1:0] ctrl;
  logic [DW-1:0]          timing;
  logic                   run, tick;

  pwm_regs #(.DW(DW), .AW(AW), .CTRL_OUT_W(CTRL_USED_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .rdata(bus_rdata),
    .ctrl_o(ctrl), .timing_o(timing)
  );

  pwm_prescaler #(.PW(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .code_i(ctrl[CODE_W-1:0]),
    .gate_i(ctrl[CTRL_GATE_BIT]), .en_i(ctrl[CTRL_EN_BIT]),
    .run_o(run), .tick_o(tick)
  );

  pwm_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
    .pol_i(ctrl[CTRL_POL_BIT]),
    .end_i(timing[2*CW-1:CW]), .duty_i(timing[CW-1:0]),
    .pwm_o(pwm_o)
  );
endmodule

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwm_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_o(pwm_o));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic cfg(input logic [3:0] code, input logic en, input logic pol, input logic gate);
    wr(3'd0, {25'd0, gate, pol, en, code});
  endtask

  task automatic tim(input logic [15:0] e, input logic [15:0] d);
    wr(3'd4, {e, d});
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk); prev = pwm_o;
    for (int g = 0; g < 60000; g++) begin
      @(negedge clk);
      if (!prev && pwm_o) return;
      prev = pwm_o;
    end
  endtask

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    while (pwm_o == lvl && n < 60000) begin n++; @(negedge clk); end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    count_run(1'b1, hi);
    count_run(1'b0, lo);
  endtask

  task automatic hold_check(input string req, input logic lvl, input int n);
    int same = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_o == lvl) same++; end
    chk(req, same, n);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    chk("R6 reset output inactive (pol 0 -> high)", pwm_o, 1);
    rd(3'd0, d); chk("R1 reset ctrl", d, 0);
    rd(3'd4, d); chk("R1 reset timing", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(3'd0, 32'hA5A5_0020);
    rd(3'd0, d); chk("R1 R9 ctrl readback", d, 32'hA5A5_0020);
    wr(3'd4, 32'hBEEF_1234);
    rd(3'd4, d); chk("R1 R9 timing readback", d, 32'hBEEF_1234);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R1 unmapped reads zero", d, 0);
    rd(3'd0, d); chk("R1 unmapped write ignored", d, 32'hA5A5_0020);
    chk("R6 gate off pol 1 -> low", pwm_o, 0);
  endtask

  task automatic t_bypass();
    int hi, lo;
    tim(16'd9, 16'd3); cfg(4'hF, 1, 1, 0); cfg(4'hF, 1, 1, 1);
    measure(hi, lo);
    chk("R2 R4 bypass high", hi, 3); chk("R2 R4 bypass low", lo, 7);
    cfg(4'hF, 1, 0, 1);
    measure(hi, lo);
    chk("R5 inverted high", hi, 7); chk("R5 inverted low", lo, 3);
  endtask

  task automatic t_duty_edges();
    cfg(4'hF, 1, 1, 1);
    tim(16'd4, 16'd5); repeat (20) @(negedge clk);
    hold_check("R4 duty above end always active", 1'b1, 30);
    tim(16'd4, 16'd0); repeat (20) @(negedge clk);
    hold_check("R4 duty zero never active", 1'b0, 30);
  endtask

  task automatic t_shadow();
    int hi, lo;
    tim(16'd9, 16'd3); repeat (30) @(negedge clk);
    wait_rise();
    tim(16'd19, 16'd10);
    count_run(1'b1, hi); count_run(1'b0, lo);
    chk("R8 mid-period write: rest of high", hi, 1);
    chk("R8 mid-period write: old low", lo, 7);
    measure(hi, lo);
    chk("R8 new high", hi, 10); chk("R8 new low", lo, 10);
  endtask

  task automatic t_collision();
    int hi, lo;
    tim(16'd9, 16'd3); repeat (40) @(negedge clk);
    wait_rise();
    repeat (8) @(negedge clk);
    tim(16'd4, 16'd2);   // write edge coincides with the wrap edge
    count_run(1'b1, hi); count_run(1'b0, lo);
    chk("R8 boundary write: period keeps old high", hi, 3);
    chk("R8 boundary write: period keeps old low", lo, 7);
    measure(hi, lo);
    chk("R8 boundary write: next high", hi, 2);
    chk("R8 boundary write: next low", lo, 3);
  endtask

  task automatic t_gate();
    int hi, lo;
    logic [31:0] d;
    tim(16'd9, 16'd3); repeat (30) @(negedge clk);
    cfg(4'h0, 1, 1, 1);
    measure(hi, lo);
    chk("R7 code change under gate ignored high", hi, 3);
    chk("R7 code change under gate ignored low", lo, 7);
    rd(3'd0, d); chk("R1 ctrl shows new code", d, 32'h0000_0070);
    cfg(4'h0, 1, 1, 0);
    chk("R6 gate cleared -> inactive", pwm_o, 0);
    cfg(4'h0, 1, 1, 1);
    measure(hi, lo);
    chk("R2 R7 div 120 high", hi, 360); chk("R2 R7 div 120 low", lo, 840);
  endtask

  task automatic t_enable();
    cfg(4'h0, 0, 1, 1);
    hold_check("R6 disabled pol 1 low", 1'b0, 20);
    cfg(4'h0, 0, 0, 1);
    hold_check("R6 disabled pol 0 high", 1'b1, 20);
  endtask

  task automatic t_codes();
    int hi, lo;
    cfg(4'h1, 0, 1, 0); tim(16'd2, 16'd2); cfg(4'h1, 1, 1, 1);
    measure(hi, lo);
    chk("R2 div 180 high", hi, 360); chk("R2 div 180 low", lo, 180);
    cfg(4'h8, 0, 1, 0); tim(16'd1, 16'd1); cfg(4'h8, 1, 1, 1);
    measure(hi, lo);
    chk("R2 div 12000 high", hi, 12000); chk("R2 div 12000 low", lo, 12000);
  endtask

  task automatic t_reserved();
    int hi, lo;
    cfg(4'h5, 1, 1, 0); cfg(4'h5, 1, 1, 1);
    hold_check("R3 code 5 stopped, pol 1 low", 1'b0, 300);
    cfg(4'hD, 1, 0, 0); cfg(4'hD, 1, 0, 1);
    hold_check("R3 code 13 stopped, pol 0 high", 1'b1, 300);
    cfg(4'hF, 1, 1, 0); cfg(4'hF, 1, 1, 1);
    measure(hi, lo);
    chk("R3 valid code restarts high", hi, 1); chk("R3 valid code restarts low", lo, 1);
  endtask

  initial begin
    #(190000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_bypass();
    t_duty_edges();
    t_shadow();
    t_collision();
    t_gate();
    t_enable();
    t_codes();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule